// File: doc/BRIEF.md
# Cache-Line Burst Planner

This block sits behind a bus master's write path and decides, one burst at a time, which write command to use and how many words the burst carries. When the cache line setting is usable, the write address sits on a line boundary and a whole line is buffered, it picks the line-invalidating write command. In that case the length is the largest power-of-two multiple of the line that fits both the words still to send and the configured burst ceiling. Otherwise it falls back to a plain memory write. A misaligned plain write is clipped so that the following burst lands on a line boundary. After every burst the choice is made again from the words left, so long transfers finish with shrinking bursts.

A transfer starts with a one-cycle `xfer_go`. It captures the start address, the word count, the line size, the burst ceiling and the single-line mode bit. The bus engine then reports each accepted word on `beat`. A latency-timer expiry during a line-invalidating burst is held off until the next line boundary. During a plain write it ends the burst after the current word. Either way the block asks for the bus to be released, then plans the next burst from where it stopped. `xfer_done` pulses once every word has been sent.

Top module: `wi_burst_planner`

## Requirements
- R1: The line-invalidating command (`cmd_wi`=1) is chosen only when all of these hold: the captured line size is one of 2, 4, 8, 16, 32, 64 or 128 words; it does not exceed the captured burst ceiling; `fifo_words` is at least one line; the current address modulo the line size is zero; and at least one line remains. Otherwise `cmd_wi`=0 (plain memory write).
- R2: A line-invalidating burst length is the largest power of two not above min(remaining words, burst ceiling), so it is always a whole number of lines. It is recomputed before every burst.
- R3: With `one_line_only` captured as 1, every line-invalidating burst is exactly one line long.
- R4: A plain write length is min(remaining, `fifo_words`, ceiling). When the line setting is usable (legal and not above the ceiling) and the address is off a boundary, it is further capped at the words up to the next boundary.
- R5: `burst_start` is high for exactly one cycle. `cmd_wi` and `burst_len` hold their values until the burst ends, and an uninterrupted burst ends after `burst_len` beats.
- R6: A latency expiry during a line-invalidating burst lets beats continue until the address reaches the next line boundary. The burst then ends, and `bus_release` pulses in the cycle after that final beat.
- R7: A latency expiry during a plain write ends the burst at that beat, with a `bus_release` pulse in the next cycle.
- R8: No burst starts while `fifo_words` is zero.
- R9: `xfer_done` pulses for one cycle after the last word has been sent; a zero-word transfer gives `xfer_done` without any burst.
- R10: Line size, ceiling, mode bit, start address and word count are sampled on `xfer_go`. Changes to those inputs during the transfer have no effect.
- R11: After a latency release the next burst is planned afresh from the current address and remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_go | input | 1 | Start a transfer (one cycle, idle only) |
| line_words | input | 8 | Cache line size in words |
| burst_cap | input | 8 | Maximum burst length in words (power of two, 2..128) |
| one_line_only | input | 1 | Restrict invalidating bursts to a single line |
| xfer_addr | input | ADDR_W | Start word address |
| xfer_words | input | CNT_W | Words to transfer |
| fifo_words | input | CNT_W | Words currently buffered |
| lat_expired | input | 1 | Latency timer has expired |
| beat | input | 1 | One word accepted by the bus this cycle |
| burst_start | output | 1 | First cycle of a burst |
| cmd_wi | output | 1 | 1: line-invalidating write, 0: plain memory write |
| burst_len | output | 8 | Planned burst length in words |
| bus_release | output | 1 | Request to give up the bus |
| xfer_done | output | 1 | Transfer finished |

## Verification
The assertions assume a legal power-of-two burst ceiling. They also assume that `beat` arrives only between `burst_start` and the end of that burst, and never beyond the planned length. The bench keeps to this by playing the bus engine itself: it drives one beat per cycle only after seeing `burst_start`, stops at the length or boundary it predicts, and drops `beat` before the block returns to planning. The sweep crosses legal and illegal line sizes, ceilings smaller and larger than the line, aligned and misaligned starts, scarce and ample buffer counts, and latency expiries that land inside and at the end of bursts. After each start the bench scrambles the configuration pins to exercise the capture behaviour.

// File: rtl/wi_burst_planner.sv
module wi_burst_planner #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_go,
  input  logic [7:0]        line_words,
  input  logic [7:0]        burst_cap,
  input  logic              one_line_only,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [CNT_W-1:0]  xfer_words,
  input  logic [CNT_W-1:0]  fifo_words,
  input  logic              lat_expired,
  input  logic              beat,
  output logic              burst_start,
  output logic              cmd_wi,
  output logic [7:0]        burst_len,
  output logic              bus_release,
  output logic              xfer_done
);
  localparam int LW = 8;

  typedef enum logic [1:0] {S_IDLE, S_PLAN, S_BURST} state_t;

  state_t            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic [LW-1:0]     cls_q, cap_q, left_q, len_q;
  logic              single_q, wi_q, lat_pend_q;
  logic              start_q, rel_q, done_q;

  function automatic logic [LW-1:0] pow2_floor(input logic [LW-1:0] v);
    logic [LW-1:0] r;
    r = '0;
    for (int i = 0; i < LW; i++) begin
      if (v[i]) begin
        r = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  logic [LW-1:0]    line_mask, off, to_edge, wi_len, mw_a, mw_len, plan_len, nxt_lo;
  logic [CNT_W-1:0] cls_w, cap_w, span, m1, m2;
  logic             cls_legal, cfg_ok, aligned, wi_pick, can_go;
  logic             in_burst, lat_any, next_aligned, stop_here;

  assign line_mask = cls_q - LW'(1);
  assign cls_legal = (cls_q != '0) && !cls_q[0] && ((cls_q & line_mask) == '0);
  assign cfg_ok    = cls_legal && (cls_q <= cap_q);
  assign off       = addr_q[LW-1:0] & line_mask;
  assign aligned   = (off == '0);
  assign to_edge   = cls_q - off;

  assign cls_w = {{(CNT_W-LW){1'b0}}, cls_q};
  assign cap_w = {{(CNT_W-LW){1'b0}}, cap_q};

  assign wi_pick = cfg_ok && aligned && (fifo_words >= cls_w) && (rem_q >= cls_w);

  assign span   = (rem_q < cap_w) ? rem_q : cap_w;
  assign wi_len = single_q ? cls_q : pow2_floor(span[LW-1:0]);

  assign m1     = (rem_q < fifo_words) ? rem_q : fifo_words;
  assign m2     = (m1 < cap_w) ? m1 : cap_w;
  assign mw_a   = m2[LW-1:0];
  assign mw_len = (cfg_ok && !aligned && (to_edge < mw_a)) ? to_edge : mw_a;

  assign plan_len = wi_pick ? wi_len : mw_len;
  assign can_go   = (state_q == S_PLAN) && (rem_q != '0) && (fifo_words != '0);

  assign in_burst     = (state_q == S_BURST);
  assign lat_any      = lat_pend_q | lat_expired;
  assign nxt_lo       = addr_q[LW-1:0] + LW'(1);
  assign next_aligned = ((nxt_lo & line_mask) == '0);
  assign stop_here    = in_burst && beat &&
                        ((left_q == LW'(1)) || (lat_any && (!wi_q || next_aligned)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      addr_q     <= '0;
      rem_q      <= '0;
      cls_q      <= '0;
      cap_q      <= '0;
      single_q   <= 1'b0;
      wi_q       <= 1'b0;
      len_q      <= '0;
      left_q     <= '0;
      lat_pend_q <= 1'b0;
      start_q    <= 1'b0;
      rel_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      start_q <= 1'b0;
      rel_q   <= 1'b0;
      done_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (xfer_go) begin
            addr_q   <= xfer_addr;
            rem_q    <= xfer_words;
            cls_q    <= line_words;
            cap_q    <= burst_cap;
            single_q <= one_line_only;
            state_q  <= S_PLAN;
          end
        end
        S_PLAN: begin
          if (rem_q == '0) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (can_go) begin
            wi_q       <= wi_pick;
            len_q      <= plan_len;
            left_q     <= plan_len;
            start_q    <= 1'b1;
            lat_pend_q <= 1'b0;
            state_q    <= S_BURST;
          end
        end
        S_BURST: begin
          if (lat_expired) lat_pend_q <= 1'b1;
          if (beat) begin
            addr_q <= addr_q + ADDR_W'(1);
            rem_q  <= rem_q - CNT_W'(1);
            left_q <= left_q - LW'(1);
          end
          if (stop_here) begin
            rel_q      <= lat_any;
            lat_pend_q <= 1'b0;
            state_q    <= S_PLAN;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign burst_start = start_q;
  assign cmd_wi      = wi_q;
  assign burst_len   = len_q;
  assign bus_release = rel_q;
  assign xfer_done   = done_q;
endmodule

// File: rtl/wi_burst_planner_chk.sv
module wi_burst_planner_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_start,
  input logic             cmd_wi,
  input logic [7:0]       burst_len,
  input logic             bus_release,
  input logic             xfer_done,
  input logic             beat,
  input logic             in_burst,
  input logic [7:0]       cls_q,
  input logic [7:0]       cap_q,
  input logic [7:0]       addr_lo,
  input logic [CNT_W-1:0] rem_q
);
  logic [7:0]       mask;
  logic [CNT_W-1:0] len_w;
  assign mask  = cls_q - 8'd1;
  assign len_w = {{(CNT_W-8){1'b0}}, burst_len};

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> !burst_start);

  // R5
  hold_cmd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && !burst_start) |-> ($stable(cmd_wi) && $stable(burst_len)));

  // R1
  wi_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && cmd_wi) |-> (((addr_lo & mask) == 8'd0) && (cls_q <= cap_q)));

  // R2
  wi_whole_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && cmd_wi) |-> (((burst_len & mask) == 8'd0) && $onehot(burst_len) && (burst_len <= cap_q)));

  // R4
  len_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> ((burst_len != 8'd0) && (len_w <= rem_q)));

  // R6
  release_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |-> ($past(beat) && !in_burst));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!in_burst && !burst_start));
endmodule

bind wi_burst_planner wi_burst_planner_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .cmd_wi(cmd_wi),
  .burst_len(burst_len), .bus_release(bus_release), .xfer_done(xfer_done),
  .beat(beat), .in_burst(in_burst), .cls_q(cls_q), .cap_q(cap_q),
  .addr_lo(addr_q[7:0]), .rem_q(rem_q)
);

// File: tb/wi_burst_planner_tb.sv
`timescale 1ns/1ps
module wi_burst_planner_tb;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              xfer_go = 1'b0;
  logic [7:0]        line_words = '0;
  logic [7:0]        burst_cap = '0;
  logic              one_line_only = 1'b0;
  logic [ADDR_W-1:0] xfer_addr = '0;
  logic [CNT_W-1:0]  xfer_words = '0;
  logic [CNT_W-1:0]  fifo_words = '0;
  logic              lat_expired = 1'b0;
  logic              beat = 1'b0;
  logic              burst_start, cmd_wi, bus_release, xfer_done;
  logic [7:0]        burst_len;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  wi_burst_planner #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_go(xfer_go), .line_words(line_words),
    .burst_cap(burst_cap), .one_line_only(one_line_only), .xfer_addr(xfer_addr),
    .xfer_words(xfer_words), .fifo_words(fifo_words), .lat_expired(lat_expired),
    .beat(beat), .burst_start(burst_start), .cmd_wi(cmd_wi), .burst_len(burst_len),
    .bus_release(bus_release), .xfer_done(xfer_done)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 190000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit legal_line(input int c);
    return (c == 2) || (c == 4) || (c == 8) || (c == 16) || (c == 32) || (c == 64) || (c == 128);
  endfunction

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int floor_p2(input int v);
    int p = 1;
    while (p * 2 <= v) p = p * 2;
    return p;
  endfunction

  task automatic run_xfer(input int cls, input int cap, input bit single, input int off,
                          input int words, input int fifo, input int lat_at, input bit starve);
    int  a, rem, gbeat, ln, cnt;
    bit  wi, lat_seen, usable, fin, seen;
    a = 32'h1000 + off;
    rem = words;
    gbeat = 0;
    usable = legal_line(cls) && (cls <= cap);
    @(negedge clk);
    line_words = 8'(cls); burst_cap = 8'(cap); one_line_only = single;
    xfer_addr = ADDR_W'(a); xfer_words = CNT_W'(words);
    fifo_words = starve ? '0 : CNT_W'(fifo);
    xfer_go = 1'b1;
    @(negedge clk);
    xfer_go = 1'b0;
    line_words = 8'd3; burst_cap = 8'd2; one_line_only = ~single;
    xfer_addr = '1; xfer_words = '0;
    if (starve) begin
      seen = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (burst_start) seen = 1'b1;
      end
      chk(!seen, "R8 burst with empty buffer", int'(seen), 0);
      fifo_words = CNT_W'(fifo);
    end
    fin = 1'b0;
    while (!fin) begin
      seen = 1'b0;
      for (int w = 0; w < 50 && !seen; w++) begin
        @(negedge clk);
        if (xfer_done || burst_start) seen = 1'b1;
      end
      if (!seen) begin
        chk(1'b0, "R9 no burst or done", 0, 1);
        fin = 1'b1;
      end else if (xfer_done) begin
        chk(rem == 0, "R9 done with words left", rem, 0);
        fin = 1'b1;
      end else begin
        wi = usable && (fifo >= cls) && (a % cls == 0) && (rem >= cls);
        if (wi) ln = single ? cls : floor_p2(min2(rem, cap));
        else begin
          ln = min2(min2(rem, fifo), cap);
          if (usable && (a % cls != 0)) ln = min2(ln, cls - (a % cls));
        end
        chk(cmd_wi == wi, "R1 command choice (R10 captured cfg)", int'(cmd_wi), int'(wi));
        if (wi && single) chk(int'(burst_len) == ln, "R3 single line length", int'(burst_len), ln);
        else if (wi) chk(int'(burst_len) == ln, "R2 multi-line length (R11 replanned)", int'(burst_len), ln);
        else chk(int'(burst_len) == ln, "R4 plain write length", int'(burst_len), ln);
        cnt = 0;
        lat_seen = 1'b0;
        while (1) begin
          beat = 1'b1;
          lat_expired = (gbeat == lat_at);
          @(negedge clk);
          if (lat_expired) lat_seen = 1'b1;
          beat = 1'b0;
          lat_expired = 1'b0;
          a++; rem--; cnt++; gbeat++;
          if (cnt == 1) chk(!burst_start, "R5 start pulse width", int'(burst_start), 0);
          if ((cnt == ln) || (lat_seen && (!wi || (a % cls == 0)))) begin
            if (wi) chk(bus_release == lat_seen, "R6 release after line edge", int'(bus_release), int'(lat_seen));
            else chk(bus_release == lat_seen, "R7 release on plain write", int'(bus_release), int'(lat_seen));
            break;
          end
          chk(!bus_release && (int'(burst_len) == ln) && (cmd_wi == wi),
              "R5 held cmd and length mid-burst", int'(burst_len), ln);
        end
      end
    end
    @(negedge clk);
    chk(!xfer_done, "R9 done pulse width", int'(xfer_done), 0);
  endtask

  initial begin
    int cls_set[5] = '{3, 2, 4, 8, 16};
    int cap_set[3] = '{4, 16, 64};
    int off_set[3] = '{0, 1, 5};
    int wrd_set[4] = '{0, 3, 37, 70};
    int fif_set[2] = '{256, 3};
    repeat (3) @(negedge clk);
    chk(!burst_start && !bus_release && !xfer_done && !cmd_wi && burst_len == 8'd0,
        "R5 reset outputs", int'(burst_len), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_xfer(8, 64, 1'b0, 0, 40, 64, -1, 1'b1);
    run_xfer(128, 128, 1'b0, 0, 300, 256, 130, 1'b0);
    for (int ci = 0; ci < 5; ci++)
      for (int pi = 0; pi < 3; pi++)
        for (int s = 0; s < 2; s++)
          for (int oi = 0; oi < 3; oi++)
            for (int wi = 0; wi < 4; wi++)
              for (int fi = 0; fi < 2; fi++)
                run_xfer(cls_set[ci], cap_set[pi], s[0], off_set[oi], wrd_set[wi], fif_set[fi],
                         (off_set[oi] == 5) ? 3 : ((off_set[oi] == 0) ? 20 : -1), 1'b0);
    summary();
  end
endmodule